// File: doc/BRIEF.md
# I2C EEPROM Write Sequencer

This block is a single-master I2C controller dedicated to one job: writing a burst of bytes into a serial EEPROM that takes a two-byte memory address. A client hands over one command, made of the three strap bits that select the device and a 16-bit memory address. The block then pulls data bytes one at a time through a valid/ready stream until it sees the byte flagged as last. It generates the start condition, the device-select byte, both address bytes, every data byte and the final stop. After every byte it checks that the slave acknowledged.

The bus pins are open-drain. The block only ever asks for a line to be pulled low (`scl_pull`, `sda_pull` high) or released. The pad pulls the line high when released, and the bus level of SDA comes back on `sda_in`. SCL timing comes from a divider: one bit takes four quarter phases of `CLK_HZ/(4*SCL_HZ)` system cycles each. SDA moves in the first quarter, while SCL is low. If any byte is not acknowledged, the block flags an error, ends the transfer with a stop and returns to idle.

Top module: `i2c_eeprom_writer`

## Requirements
- R1: During and right after reset, and while idle, both pull controls are low (lines released), `cmd_ready` is high, and `busy`, `done`, `nack_err` and `dat_ready` are low. A reset in the middle of a transfer releases both lines and returns to this state.
- R2: Every transfer begins with exactly one start condition: SDA goes from high to low while SCL is high, before the first SCL rising edge.
- R3: The first byte on the bus is binary 1010, then strap bits [2:1:0], then a 0 write bit. It is sent most significant bit first, one bit per SCL rising edge.
- R4: After the device byte come `cmd_mem_addr[15:8]`, then `cmd_mem_addr[7:0]`, then the streamed data bytes in stream order. The byte accepted with `dat_last` high is the final one, and no byte is accepted before the low address byte has been acknowledged.
- R5: Inside a byte, SDA changes only while SCL is low. No start or stop appears between the opening start and the closing stop.
- R6: Each byte takes nine SCL pulses. During the ninth, the block releases SDA, and the slave's level there is the acknowledge (low means acknowledged).
- R7: After the acknowledged last data byte, the block issues a stop: SDA goes from low to high while SCL is high. After that both lines stay released, `done` is high for exactly one cycle and `nack_err` is low.
- R8: If any byte is answered with SDA high, `nack_err` goes high and stays high until the next command. The block issues a stop, sends no more bytes, accepts no more stream bytes, and pulses `done` once.
- R9: Successive SCL rising edges within a byte are exactly `4*(CLK_HZ/(4*SCL_HZ))` system cycles apart.
- R10: `cmd_ready` is low from the cycle after a command is accepted until the transfer ends. A `cmd_valid` in that window has no effect, either on the bytes sent or by starting a second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_strap | input | 3 | Device select strap bits |
| cmd_mem_addr | input | 16 | EEPROM memory address |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Data byte taken this cycle when valid |
| dat_byte | input | 8 | Data byte |
| dat_last | input | 1 | Marks the final data byte |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level read back from the SDA line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer has ended |
| nack_err | output | 1 | Missing acknowledge seen in the last transfer |

## Verification
The bench targets transfers where a missing acknowledge hits the device byte, the low address byte or a middle data byte. A design that ignored the acknowledge would keep clocking out bytes or draining the stream, and one that skipped the stop would leave SCL held low. Stream bytes that arrive with idle gaps check that the block waits instead of sending stale data, and a single-byte burst checks that the last flag is honoured on the very first data byte. A command offered mid-transfer and a reset mid-transfer check that a sloppy handshake does not restart the sequence and that a reset does not leave a line pulled.

// File: rtl/eew_pkg.sv
package eew_pkg;

    localparam logic [3:0] DEV_FAMILY = 4'b1010;

    typedef enum logic [1:0] {
        OP_START,
        OP_BYTE,
        OP_STOP
    } bus_op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_BITS,
        PH_STOP
    } phy_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_DEV,
        SQ_AHI,
        SQ_ALO,
        SQ_FETCH,
        SQ_DATA,
        SQ_STOP
    } seq_state_e;

    typedef struct packed {
        logic [2:0]  strap;
        logic [15:0] mem_addr;
    } wr_cmd_t;

    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
    } pin_drive_t;

    function automatic int quarter_cycles(input int clk_hz, input int scl_hz);
        return clk_hz / (4 * scl_hz);
    endfunction

    function automatic logic [7:0] dev_write_byte(input logic [2:0] strap);
        return {DEV_FAMILY, strap, 1'b0};
    endfunction

endpackage

// File: rtl/eew_quarter_tick.sv
module eew_quarter_tick #(
    parameter int QUARTER = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);

    generate
        if (QUARTER > 1) begin : g_spacing
            assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/eew_bit_phy.sv
module eew_bit_phy
    import eew_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       go,
    input  bus_op_e    op,
    input  logic [7:0] tx_byte,
    input  logic       sda_in,
    output logic       active,
    output logic       done,
    output logic       nack,
    output logic       scl_pull,
    output logic       sda_pull
);
    phy_state_e  state;
    logic [1:0]  qcnt;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic [1:0]  sda_sync;
    logic        samp;
    pin_drive_t  drv_q;
    pin_drive_t  nxt;

    // Pin pattern per quarter; registered so the pads see clean levels.
    always_comb begin
        nxt = drv_q;
        unique case (state)
            PH_START: begin
                nxt.scl_pull = (qcnt >= 2'd2);
                nxt.sda_pull = (qcnt >= 2'd1);
            end
            PH_BITS: begin
                nxt.scl_pull = (qcnt == 2'd0) || (qcnt == 2'd3);
                nxt.sda_pull = (bitcnt == 4'd8) ? 1'b0 : ~shreg[7];
            end
            PH_STOP: begin
                nxt.scl_pull = (qcnt == 2'd0);
                nxt.sda_pull = (qcnt <= 2'd1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_IDLE;
            qcnt     <= '0;
            bitcnt   <= '0;
            shreg    <= '0;
            sda_sync <= 2'b11;
            samp     <= 1'b1;
            done     <= 1'b0;
            drv_q    <= '0;
        end else begin
            done     <= 1'b0;
            drv_q    <= nxt;
            sda_sync <= {sda_sync[0], sda_in};
            if (state == PH_IDLE) begin
                if (go) begin
                    qcnt   <= '0;
                    bitcnt <= '0;
                    shreg  <= tx_byte;
                    unique case (op)
                        OP_START: state <= PH_START;
                        OP_STOP:  state <= PH_STOP;
                        default:  state <= PH_BITS;
                    endcase
                end
            end else if (tick) begin
                qcnt <= qcnt + 1'b1;
                if (state == PH_BITS && qcnt == 2'd1) begin
                    samp <= sda_sync[1];
                end
                if (qcnt == 2'd3) begin
                    if (state == PH_BITS) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 4'd8) begin
                            state <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    end else begin
                        state <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
            end
        end
    end

    assign active   = (state != PH_IDLE);
    assign nack     = samp;
    assign scl_pull = drv_q.scl_pull;
    assign sda_pull = drv_q.sda_pull;

    // R5: data line frozen while the clock line is released inside a byte
    assert_sda_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PH_BITS && !drv_q.scl_pull && !$past(drv_q.scl_pull))
            |-> $stable(drv_q.sda_pull));

    // R6: ninth slot leaves SDA to the slave
    assert_ack_release_R6: assert property (@(posedge clk) disable iff (rst)
        (state == PH_BITS && bitcnt == 4'd8 && qcnt != 2'd0) |-> !drv_q.sda_pull);

endmodule

// File: rtl/eew_seq.sv
module eew_seq
    import eew_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  wr_cmd_t    cmd,
    input  logic       dat_valid,
    output logic       dat_ready,
    input  logic [7:0] dat_byte,
    input  logic       dat_last,
    output logic       phy_go,
    output bus_op_e    phy_op,
    output logic [7:0] phy_byte,
    input  logic       phy_done,
    input  logic       phy_nack,
    output logic       busy,
    output logic       done,
    output logic       nack_err
);
    seq_state_e state;
    wr_cmd_t    cmd_q;
    logic       last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cmd_q    <= '0;
            last_q   <= 1'b0;
            phy_go   <= 1'b0;
            phy_op   <= OP_START;
            phy_byte <= '0;
            done     <= 1'b0;
            nack_err <= 1'b0;
        end else begin
            phy_go <= 1'b0;
            done   <= 1'b0;
            unique case (state)
                SQ_IDLE: if (cmd_valid) begin
                    cmd_q    <= cmd;
                    nack_err <= 1'b0;
                    phy_go   <= 1'b1;
                    phy_op   <= OP_START;
                    state    <= SQ_START;
                end
                SQ_START: if (phy_done) begin
                    phy_go   <= 1'b1;
                    phy_op   <= OP_BYTE;
                    phy_byte <= dev_write_byte(cmd_q.strap);
                    state    <= SQ_DEV;
                end
                SQ_DEV, SQ_AHI, SQ_ALO, SQ_DATA: if (phy_done) begin
                    if (phy_nack || (state == SQ_DATA && last_q)) begin
                        nack_err <= phy_nack;
                        phy_go   <= 1'b1;
                        phy_op   <= OP_STOP;
                        state    <= SQ_STOP;
                    end else if (state == SQ_DEV) begin
                        phy_go   <= 1'b1;
                        phy_op   <= OP_BYTE;
                        phy_byte <= cmd_q.mem_addr[15:8];
                        state    <= SQ_AHI;
                    end else if (state == SQ_AHI) begin
                        phy_go   <= 1'b1;
                        phy_op   <= OP_BYTE;
                        phy_byte <= cmd_q.mem_addr[7:0];
                        state    <= SQ_ALO;
                    end else begin
                        state    <= SQ_FETCH;
                    end
                end
                SQ_FETCH: if (dat_valid) begin
                    last_q   <= dat_last;
                    phy_go   <= 1'b1;
                    phy_op   <= OP_BYTE;
                    phy_byte <= dat_byte;
                    state    <= SQ_DATA;
                end
                SQ_STOP: if (phy_done) begin
                    done  <= 1'b1;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == SQ_IDLE);
    assign dat_ready = (state == SQ_FETCH);
    assign busy      = (state != SQ_IDLE);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_cmd_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

    assert_nack_halts_stream_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && nack_err) |-> !dat_ready);

    assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);

endmodule

// File: rtl/i2c_eeprom_writer.sv
module i2c_eeprom_writer
    import eew_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000,
    parameter int SCL_HZ = 100_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [2:0]  cmd_strap,
    input  logic [15:0] cmd_mem_addr,
    input  logic        dat_valid,
    output logic        dat_ready,
    input  logic [7:0]  dat_byte,
    input  logic        dat_last,
    output logic        scl_pull,
    output logic        sda_pull,
    input  logic        sda_in,
    output logic        busy,
    output logic        done,
    output logic        nack_err
);
    localparam int QUARTER = quarter_cycles(CLK_HZ, SCL_HZ);

    wr_cmd_t    cmd_s;
    logic       tick;
    logic       phy_active;
    logic       phy_go;
    bus_op_e    phy_op;
    logic [7:0] phy_byte;
    logic       phy_done;
    logic       phy_nack;

    assign cmd_s = '{strap: cmd_strap, mem_addr: cmd_mem_addr};

    eew_quarter_tick #(.QUARTER(QUARTER)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (phy_active),
        .tick (tick)
    );

    eew_bit_phy u_phy (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .go       (phy_go),
        .op       (phy_op),
        .tx_byte  (phy_byte),
        .sda_in   (sda_in),
        .active   (phy_active),
        .done     (phy_done),
        .nack     (phy_nack),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull)
    );

    eew_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd       (cmd_s),
        .dat_valid (dat_valid),
        .dat_ready (dat_ready),
        .dat_byte  (dat_byte),
        .dat_last  (dat_last),
        .phy_go    (phy_go),
        .phy_op    (phy_op),
        .phy_byte  (phy_byte),
        .phy_done  (phy_done),
        .phy_nack  (phy_nack),
        .busy      (busy),
        .done      (done),
        .nack_err  (nack_err)
    );

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && $past(cmd_ready)) |-> (!scl_pull && !sda_pull));

endmodule

// File: tb/i2c_eeprom_writer_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_writer_tb;

    localparam int CLK_HZ  = 800_000;
    localparam int SCL_HZ  = 100_000;
    localparam int BIT_CYC = 4 * (CLK_HZ / (4 * SCL_HZ));

    typedef struct packed {
        logic [2:0]  strap;
        logic [15:0] addr;
        logic [3:0]  n;
        logic [3:0]  nk;    // byte index the slave refuses, F = none
        logic [7:0]  seed;
        logic [3:0]  gap;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'b101, 16'h1234, 4'd1, 4'hF, 8'h5A, 4'd0},
        '{3'b000, 16'hABCD, 4'd4, 4'hF, 8'h00, 4'd3},
        '{3'b111, 16'h0000, 4'd3, 4'd4, 8'hC3, 4'd0},
        '{3'b010, 16'hFFFF, 4'd2, 4'd0, 8'h11, 4'd0},
        '{3'b110, 16'h0F0F, 4'd2, 4'd2, 8'h77, 4'd1},
        '{3'b011, 16'h8001, 4'd5, 4'hF, 8'hFF, 4'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_strap = '0;
    logic [15:0] cmd_mem_addr = '0;
    logic        dat_valid = 1'b0;
    logic        dat_ready;
    logic [7:0]  dat_byte = '0;
    logic        dat_last = 1'b0;
    logic        scl_pull, sda_pull, busy, done, nack_err;
    logic        slave_pull = 1'b0;
    logic        scl_line, sda_line;

    assign scl_line = ~scl_pull;
    assign sda_line = ~(sda_pull | slave_pull);

    i2c_eeprom_writer #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_strap(cmd_strap), .cmd_mem_addr(cmd_mem_addr),
        .dat_valid(dat_valid), .dat_ready(dat_ready),
        .dat_byte(dat_byte), .dat_last(dat_last),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_line),
        .busy(busy), .done(done), .nack_err(nack_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- bus monitor and slave model ----------------
    logic       mon_clr = 1'b0;
    int         nack_index = -1;
    int         starts = 0, stops = 0, log_n = 0, bad_period = 0;
    int         mon_bits = 0, cyc = 0, last_rise = -1;
    logic [7:0] mon_shift = '0;
    logic [7:0] log_bytes [16];
    logic       prev_scl = 1'b1, prev_sda = 1'b1;

    always @(negedge clk) begin
        logic cs, ds;
        cs = scl_line;
        ds = sda_line;
        cyc++;
        if (mon_clr) begin
            starts = 0; stops = 0; log_n = 0; mon_bits = 0;
            bad_period = 0; slave_pull = 1'b0; last_rise = -1;
        end else begin
            if (cs && prev_scl) begin
                if (prev_sda && !ds) begin starts++; mon_bits = 0; end
                if (!prev_sda && ds) begin stops++;  mon_bits = 0; end
            end
            if (cs && !prev_scl) begin
                if (mon_bits > 0 && last_rise >= 0 && (cyc - last_rise) != BIT_CYC)
                    bad_period++;
                last_rise = cyc;
                if (mon_bits < 8) mon_shift = {mon_shift[6:0], ds};
                mon_bits++;
            end
            if (!cs && prev_scl) begin
                if (mon_bits == 8) begin
                    slave_pull = (log_n != nack_index);
                end else if (mon_bits == 9) begin
                    slave_pull = 1'b0;
                    if (log_n < 16) log_bytes[log_n] = mon_shift;
                    log_n++;
                    mon_bits = 0;
                end
            end
        end
        prev_scl = cs;
        prev_sda = ds;
    end

    // ---------------- data stream source ----------------
    logic       feed_clr = 1'b0;
    int         feed_n = 0, feed_idx = 0, feed_gap = 0, gap_cnt = 0;
    logic [7:0] feed_seed = '0;
    logic       took = 1'b0;

    always @(posedge clk) took <= dat_valid && dat_ready;

    always @(negedge clk) begin
        if (feed_clr) begin
            feed_idx = 0;
            gap_cnt  = feed_gap;
            dat_valid = 1'b0;
        end else begin
            if (took) begin
                feed_idx++;
                gap_cnt = feed_gap;
            end else if (!dat_valid && gap_cnt > 0) begin
                gap_cnt--;
            end
            dat_valid = (feed_idx < feed_n) && (gap_cnt == 0);
            dat_byte  = feed_seed + 8'(feed_idx * 37);
            dat_last  = (feed_idx == feed_n - 1);
        end
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", wd);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic prep(input int nk, input int n, input logic [7:0] seed, input int gap);
        @(negedge clk);
        mon_clr = 1'b1; feed_clr = 1'b1;
        nack_index = nk; feed_n = n; feed_seed = seed; feed_gap = gap;
        @(negedge clk);
        @(negedge clk);
        mon_clr = 1'b0; feed_clr = 1'b0;
    endtask

    task automatic run_txn(input logic [2:0] strap, input logic [15:0] addr, input int n,
                           input int nk, input logic [7:0] seed, input int gap, input bit inject);
        logic [7:0] exp [16];
        int exp_n, exp_take, t;
        prep(nk, n, seed, gap);
        exp[0] = {4'b1010, strap, 1'b0};
        exp[1] = addr[15:8];
        exp[2] = addr[7:0];
        for (int i = 0; i < n; i++) exp[3+i] = seed + 8'(i * 37);
        exp_n    = (nk < 0) ? 3 + n : nk + 1;
        exp_take = (nk < 0) ? n : ((nk >= 3) ? nk - 2 : 0);

        chk("R10", "cmd_ready before command", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_strap = strap; cmd_mem_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (inject) begin
            repeat (20) @(negedge clk);
            chk("R10", "cmd_ready while busy", cmd_ready, 0);
            cmd_valid = 1'b1; cmd_strap = ~strap; cmd_mem_addr = ~addr;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk("R7", "done seen", done, 1);
        chk("R8", "nack_err at done", nack_err, (nk >= 0) ? 1 : 0);
        chk("R2", "start count", starts, 1);
        chk("R7", "stop count", stops, 1);
        chk("R9", "scl period deviations", bad_period, 0);
        chk("R4", "bytes on bus", log_n, exp_n);
        chk("R8", "stream bytes taken", feed_idx, exp_take);
        for (int i = 0; i < exp_n && i < log_n && i < 16; i++)
            chk((i == 0) ? "R3" : "R4", $sformatf("bus byte %0d", i), log_bytes[i], exp[i]);
        @(negedge clk);
        chk("R7", "done single cycle", done, 0);
        chk("R7", "lines released after stop", {scl_pull, sda_pull}, 2'b00);
        if (inject) begin
            repeat (200) @(negedge clk);
            chk("R10", "no second transfer", starts, 1);
            chk("R10", "idle after ignored command", busy, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "pulls in reset", {scl_pull, sda_pull}, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "cmd_ready idle", cmd_ready, 1);
        chk("R1", "busy/done/err idle", {busy, done, nack_err, dat_ready}, 4'b0000);
        chk("R1", "lines released idle", {scl_pull, sda_pull}, 2'b00);

        for (int v = 0; v < NV; v++) begin
            run_txn(VECS[v].strap, VECS[v].addr, int'(VECS[v].n),
                    (VECS[v].nk == 4'hF) ? -1 : int'(VECS[v].nk),
                    VECS[v].seed, int'(VECS[v].gap), 1'b0);
        end

        // command offered mid transfer must be ignored
        run_txn(3'b100, 16'h5AA5, 2, -1, 8'h3C, 0, 1'b1);

        // error flag from a refused transfer clears on a clean one
        run_txn(3'b001, 16'h0101, 1, 1, 8'h00, 0, 1'b0);
        run_txn(3'b001, 16'h0102, 1, -1, 8'h42, 0, 1'b0);

        // reset in the middle of a transfer
        prep(-1, 3, 8'h99, 0);
        cmd_valid = 1'b1; cmd_strap = 3'b011; cmd_mem_addr = 16'h2222;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (100) @(negedge clk);
        chk("R1", "busy before mid reset", busy, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1", "lines released after mid reset", {scl_pull, sda_pull}, 2'b00);
        chk("R1", "state after mid reset", {cmd_ready, busy, done, nack_err, dat_ready}, 5'b10000);
        feed_n = 0;
        prep(-1, 0, 8'h00, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule